// File: doc/BRIEF.md
# POLYVAL Montgomery Field Multiplier

This block multiplies two elements of GF(2^128) in the form the POLYVAL universal hash needs. The result is the carry-less product of the two operands, multiplied by x^-128 and reduced modulo x^128 + x^127 + x^126 + x^121 + 1. When both inputs are in Montgomery form, the result is the Montgomery form of their product. Both operands and the result use little-endian bit order: bit i of a 128-bit word is the coefficient of x^i.

One 64x64 carry-less multiplier is used six times in a row. The first four passes form the low-by-low, high-by-high and two cross partial products of a schoolbook 256-bit product. The last two passes apply a two-step folding reduction with the 64-bit constant 0xC200000000000000. A host raises `start` for one cycle with both operands while `busy` is low. It then waits for the one-cycle `done` pulse, and `result` holds the answer until the next operation completes.

Top module: `polyval_mont_mul`

## Requirements
- R1: After a synchronous active-low reset, `busy` and `done` are 0 and `result` is 0.
- R2: `result` equals op_a·op_b·x^-128 mod (x^128 + x^127 + x^126 + x^121 + 1), where bit i of every 128-bit word is the coefficient of x^i.
- R3: With op_b = 128'hC2000000_00000000_00000000_00000001 (x^128 reduced by the modulus), `result` equals op_a.
- R4: If either operand is zero, `result` is zero.
- R5: If `start` is sampled high at clock edge N while `busy` is low, `done` is high for exactly the one cycle that follows edge N+6.
- R6: `busy` is high from the edge that accepts a start until the edge that raises `done`, and it is never high together with `done`.
- R7: `start` sampled while `busy` is high is ignored. It changes neither the result nor the completion time, and it causes no extra `done` pulse.
- R8: `result` changes only on the edge that raises `done`, and holds its value otherwise.
- R9: A `start` presented in the cycle where `done` is high is accepted, so operations can run back to back.
- R10: The product is symmetric: swapping op_a and op_b gives the same `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a multiplication; taken only while idle |
| op_a | input | 128 | First operand, sampled with an accepted start |
| op_b | input | 128 | Second operand, sampled with an accepted start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: `result` is new and valid |
| result | output | 128 | Montgomery product, held until the next completion |

## Verification
Completion of one operation and acceptance of the next can fall in the same cycle. The `done` pulse coincides with `busy` dropping, so a `start` held in that cycle must be taken, while the finished `result` stays visible. The bench provokes this by presenting a second start at the sample point where it first sees `done`. It then checks that the first result is correct in that cycle, that the second result is correct, and that the second result arrives exactly seven sample points later. A start presented in the middle of a busy operation is also injected, to show that it does not disturb the operation in flight.

// File: rtl/polyval_pkg.sv
// Shared widths, fold constant and step encoding for the POLYVAL multiplier.
// Assumes the field width is 128 bits; half-word width is derived from it.
package polyval_pkg;
    localparam int unsigned PV_W = 128;
    localparam int unsigned PV_H = PV_W / 2;
    localparam logic [PV_H-1:0] PV_FOLD = 64'hC200000000000000;

    // Sequence of uses of the shared carry-less multiplier.
    typedef enum logic [2:0] {
        ST_LL = 3'd0,  // low x low
        ST_HH = 3'd1,  // high x high
        ST_LH = 3'd2,  // low(a) x high(b)
        ST_HL = 3'd3,  // high(a) x low(b)
        ST_F1 = 3'd4,  // first fold
        ST_F2 = 3'd5   // second fold, result out
    } pv_step_e;
endpackage

// File: rtl/pv_clmul.sv
// Combinational carry-less multiplier of two W-bit words.
// Assumes nothing about the operands; the product is 2*W bits wide.
module pv_clmul #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] p
);
    localparam int unsigned PW = 2 * W;

    // XOR together one shifted copy of x for every set bit of y.
    always_comb begin
        p = '0;
        for (int i = 0; i < W; i++) begin
            if (y[i]) p = p ^ ({{W{1'b0}}, x} << i);
        end
    end

    // Multiplying by 1 must hand back x unchanged.
    always_comb begin
        if (y == {{(W-1){1'b0}}, 1'b1}) begin
            a_r2_clmul_unit: assert (p == {{W{1'b0}}, x})
                else $error("clmul by one altered the operand");
        end
    end

    logic unused_pw;
    assign unused_pw = (PW == 0);
endmodule

// File: rtl/pv_ctrl.sv
// Sequencer for the multiplier: accepts a start while idle, then walks the
// six steps in order and pulses done after the last one.
// Assumes start is only meaningful while busy is low; otherwise ignored.
module pv_ctrl
    import polyval_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    output logic     busy,
    output logic     load,
    output pv_step_e step,
    output logic     done
);
    assign load = start && !busy;

    // Track busy, the current step and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            step <= ST_LL;
            done <= 1'b0;
        end else begin
            done <= busy && (step == ST_F2);
            if (load) begin
                busy <= 1'b1;
                step <= ST_LL;
            end else if (busy) begin
                if (step == ST_F2) begin
                    busy <= 1'b0;
                    step <= ST_LL;
                end else begin
                    step <= pv_step_e'(step + 3'd1);
                end
            end
        end
    end

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r6_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && step == ST_LL));

    a_r7_step_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step != ST_F2) |=> (busy && step == pv_step_e'($past(step) + 3'd1)));

    a_r5_last_step_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step == ST_F2) |=> (done && !busy));

    a_r5_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        step <= ST_F2);
endmodule

// File: rtl/pv_accum.sv
// Operand store, multiplier input selection and 256-bit accumulator.
// Four passes build the schoolbook product in {hi_q, lo_q}; two fold passes
// reduce it, and the last one writes the high half to the result register.
// Assumes load and busy come from the sequencer and are never high together
// in a way that matters: load wins.
module pv_accum
    import polyval_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              busy,
    input  pv_step_e          step,
    input  logic [PV_W-1:0]   op_a,
    input  logic [PV_W-1:0]   op_b,
    input  logic [PV_W-1:0]   prod,
    output logic [PV_H-1:0]   mul_x,
    output logic [PV_H-1:0]   mul_y,
    output logic [PV_W-1:0]   result
);
    logic [PV_W-1:0] a_q, b_q, lo_q, hi_q;
    logic [PV_W-1:0] prod_swap;

    assign prod_swap = {prod[PV_H-1:0], prod[PV_W-1:PV_H]};

    // Route the right words to the shared multiplier for each step.
    always_comb begin
        unique case (step)
            ST_LL:   begin mul_x = a_q[PV_H-1:0];    mul_y = b_q[PV_H-1:0];    end
            ST_HH:   begin mul_x = a_q[PV_W-1:PV_H]; mul_y = b_q[PV_W-1:PV_H]; end
            ST_LH:   begin mul_x = a_q[PV_H-1:0];    mul_y = b_q[PV_W-1:PV_H]; end
            ST_HL:   begin mul_x = a_q[PV_W-1:PV_H]; mul_y = b_q[PV_H-1:0];    end
            ST_F1:   begin mul_x = lo_q[PV_H-1:0];    mul_y = PV_FOLD;          end
            ST_F2:   begin mul_x = lo_q[PV_W-1:PV_H]; mul_y = PV_FOLD;          end
            default: begin mul_x = '0;                mul_y = '0;               end
        endcase
    end

    // Capture operands, accumulate partial products, fold, and publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            result <= '0;
        end else if (load) begin
            a_q <= op_a;
            b_q <= op_b;
        end else if (busy) begin
            unique case (step)
                ST_LL: lo_q <= prod;
                ST_HH: hi_q <= prod;
                ST_LH, ST_HL: begin
                    lo_q[PV_W-1:PV_H] <= lo_q[PV_W-1:PV_H] ^ prod[PV_H-1:0];
                    hi_q[PV_H-1:0]    <= hi_q[PV_H-1:0]    ^ prod[PV_W-1:PV_H];
                end
                ST_F1: lo_q <= lo_q ^ prod_swap;
                ST_F2: result <= hi_q ^ lo_q ^ prod;
                default: ;
            endcase
        end
    end

    // The fold passes always use the fixed constant as one factor.
    a_r2_fold_const: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (step == ST_F1 || step == ST_F2)) |-> (mul_y == PV_FOLD));

    // Operands are frozen while an operation is in flight.
    a_r7_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/polyval_mont_mul.sv
// POLYVAL Montgomery multiplier top: result = a*b*x^-128 mod
// x^128+x^127+x^126+x^121+1, with one shared 64x64 carry-less multiplier
// used over six cycles. Assumes little-endian coefficient order.
module polyval_mont_mul
    import polyval_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [127:0]    op_a,
    input  logic [127:0]    op_b,
    output logic            busy,
    output logic            done,
    output logic [127:0]    result
);
    logic            load;
    pv_step_e        step;
    logic [PV_H-1:0] mul_x, mul_y;
    logic [PV_W-1:0] prod;

    pv_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .load  (load),
        .step  (step),
        .done  (done)
    );

    pv_accum u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .busy   (busy),
        .step   (step),
        .op_a   (op_a),
        .op_b   (op_b),
        .prod   (prod),
        .mul_x  (mul_x),
        .mul_y  (mul_y),
        .result (result)
    );

    pv_clmul #(.W(PV_H)) u_clmul (
        .x (mul_x),
        .y (mul_y),
        .p (prod)
    );

    // Result register only moves on the edge that raises done.
    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // A start seen while busy must not cut the operation short.
    a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && step != ST_F2) |=> busy);
endmodule

// File: tb/polyval_mont_mul_tb.sv
module polyval_mont_mul_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] op_a = '0;
    logic [127:0] op_b = '0;
    logic         busy, done;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;

    localparam logic [255:0] MODP = 256'h1_C2000000_00000000_00000000_00000001;
    localparam logic [127:0] MONT_ONE = 128'hC2000000_00000000_00000000_00000001;
    localparam int NV = 8;
    localparam logic [255:0] VEC [NV] = '{
        {128'h00000000_00000000_00000000_00000001, 128'h00000000_00000000_00000000_00000001},
        {128'h80000000_00000000_00000000_00000000, 128'h80000000_00000000_00000000_00000000},
        {128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF},
        {128'h0123456789ABCDEF_FEDCBA9876543210, 128'h0F1E2D3C4B5A6978_8796A5B4C3D2E1F0},
        {128'h25629347589242761D31F826BA4B757B, 128'h4F4F95668C83DFB6401762BB2D01A262},
        {128'h00000000_00000001_00000000_00000000, 128'hDEADBEEF_00C0FFEE_13579BDF_2468ACE0},
        {128'hAAAAAAAA_AAAAAAAA_55555555_55555555, 128'h33333333_CCCCCCCC_0F0F0F0F_F0F0F0F0},
        {128'h00000000_00000000_C2000000_00000000, 128'hC2000000_00000000_00000000_00000000}
    };

    polyval_mont_mul u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .result(result)
    );

    always #5 clk = ~clk;

    // Bit-serial model: full product, then 128 divisions by x.
    function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
        logic [255:0] p;
        p = '0;
        for (int i = 0; i < 128; i++) if (b[i]) p = p ^ ({128'b0, a} << i);
        for (int i = 0; i < 128; i++) begin
            if (p[0]) p = p ^ MODP;
            p = p >> 1;
        end
        return p[127:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one operation and wait for done; returns result and sample count.
    task automatic run_op(input logic [127:0] a, input logic [127:0] b,
                          output logic [127:0] r, output int lat);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        r = result;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] r, r2, exp;
        int lat;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && result == 0, "R1 reset state",
              {126'b0, busy, done}, 128'h0);
        check(result == 0, "R1 reset result", result, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 against the model, R5 latency, R10 symmetry.
        for (int k = 0; k < NV; k++) begin
            exp = ref_mul(VEC[k][255:128], VEC[k][127:0]);
            run_op(VEC[k][255:128], VEC[k][127:0], r, lat);
            check(r == exp, "R2 product", r, exp);
            check(lat == 7, "R5 latency", 128'(lat), 128'd7);
            @(negedge clk);
            check(done == 0, "R5 done one cycle", {127'b0, done}, 128'h0);
            run_op(VEC[k][127:0], VEC[k][255:128], r2, lat);
            check(r2 == exp, "R10 swapped operands", r2, exp);
            @(negedge clk);
        end

        // R3: Montgomery one is the identity.
        run_op(128'h0123456789ABCDEF_FEDCBA9876543210, MONT_ONE, r, lat);
        check(r == 128'h0123456789ABCDEF_FEDCBA9876543210, "R3 identity", r,
              128'h0123456789ABCDEF_FEDCBA9876543210);
        @(negedge clk);

        // R4: zero operand gives zero.
        run_op(128'h0, 128'hFFFF0000_1234ABCD_DEADBEEF_00000001, r, lat);
        check(r == 0, "R4 zero a", r, 128'h0);
        @(negedge clk);
        run_op(128'hFFFF0000_1234ABCD_DEADBEEF_00000001, 128'h0, r, lat);
        check(r == 0, "R4 zero b", r, 128'h0);
        @(negedge clk);

        // R6 busy window and R7 start while busy.
        exp = ref_mul(VEC[3][255:128], VEC[3][127:0]);
        op_a = VEC[3][255:128]; op_b = VEC[3][127:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1, "R6 busy after accept", {127'b0, busy}, 128'h1);
        @(negedge clk);
        op_a = VEC[2][255:128]; op_b = 128'h5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R8: result still holds previous value mid-operation.
        check(result == 0, "R8 result held while busy", result, 128'h0);
        repeat (3) @(negedge clk);
        check(done == 0 && busy == 1, "R7 no early done", {126'b0, busy, done}, 128'h2);
        @(negedge clk);
        check(done == 1 && busy == 0, "R6 busy drops with done", {126'b0, busy, done}, 128'h1);
        check(result == exp, "R7 busy start ignored", result, exp);
        begin
            int extra = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (done) extra++;
            end
            check(extra == 0, "R7 no extra done", 128'(extra), 128'h0);
        end

        // R9: start in the done cycle is accepted.
        exp = ref_mul(VEC[4][255:128], VEC[4][127:0]);
        run_op(VEC[4][255:128], VEC[4][127:0], r, lat);
        check(r == exp, "R9 first of pair", r, exp);
        exp = ref_mul(VEC[6][255:128], VEC[6][127:0]);
        run_op(VEC[6][255:128], VEC[6][127:0], r2, lat);
        check(lat == 7, "R9 back-to-back latency", 128'(lat), 128'd7);
        check(r2 == exp, "R9 second of pair", r2, exp);
        @(negedge clk);
        check(result == exp, "R8 result holds after done", result, exp);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule